// File: doc/BRIEF.md
# Dual-Stream Affine Point Transformer

This block transforms a stream of 3-D points with an affine map held as twelve programmable coefficients. It holds two such coefficient sets, called L and R. In parallel mode every point passes through both sets at once, giving a left-eye stream and a right-eye stream. In chained mode the point goes through set L, and that result then goes through set R. Only the left stream carries results in chained mode.

Points arrive as 64-bit pipeline words that hold packed signed 10-bit coordinates. Each output coordinate is a signed 16-bit value, clamped after exact accumulation. Coefficients are written through a write-only port that returns no data. The input and both outputs use valid/ready handshakes. The pipeline stalls as one unit whenever either output holds a result that its sink has not yet taken.

Top module: `stereo_affine_xform`

## Requirements
- R1: x, y and z are signed 10-bit values taken from in_word bits [9:0], [25:16] and [41:32]. All other bits of in_word, including the spare lane [57:48], have no effect on any result.
- R2: A coefficient set is c0..c11, each signed 16-bit, written at cfg_idx 0..11. cfg_sel=0 selects set L and cfg_sel=1 selects set R. Output axis r (0=x, 1=y, 2=z) equals x*c(4r) + y*c(4r+1) + z*c(4r+2) + c(4r+3).
- R3: Sums are formed exactly and then clamped to the range -32768..32767. Clamping is applied after set L and again after set R.
- R4: In parallel mode (chain_en=0), the left output carries set L and the right output carries set R for the same point. The right result never becomes valid without the left result becoming valid in the same cycle.
- R5: In chained mode (chain_en=1), the left output is set R applied to the clamped set-L result, and r_valid stays low.
- R6: Without backpressure, a point accepted in cycle t appears with l_valid high in cycle t+3, and one point can be accepted every cycle.
- R7: While valid is high and ready is low, an output keeps its valid and data unchanged. in_ready is low whenever either output holds an untaken result, so a parallel-mode point waits until both channels can take a result.
- R8: A coefficient write in the acceptance cycle of a point, or later, does not change that point's results.
- R9: Writes with cfg_idx 12..15 change no coefficient.
- R10: After synchronous reset, l_valid and r_valid are low, in_ready is high, and all coefficients are zero.
- R11: The mode is sampled with each point at acceptance, so parallel and chained points may follow each other back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Coefficient set: 0 = L, 1 = R |
| cfg_idx | input | 4 | Coefficient index 0..11 |
| cfg_data | input | 16 | Signed coefficient value |
| chain_en | input | 1 | 0 = parallel pair, 1 = chained L then R |
| in_valid | input | 1 | Input point valid |
| in_ready | output | 1 | Input point can be accepted |
| in_word | input | 64 | Packed input point |
| l_valid | output | 1 | Left result valid |
| l_ready | input | 1 | Left sink ready |
| l_x | output | 16 | Left result x |
| l_y | output | 16 | Left result y |
| l_z | output | 16 | Left result z |
| r_valid | output | 1 | Right result valid |
| r_ready | input | 1 | Right sink ready |
| r_x | output | 16 | Right result x |
| r_y | output | 16 | Right result y |
| r_z | output | 16 | Right result z |

## Verification
Two kinds of event can share a cycle: a coefficient write and the acceptance of a point that must still use the old values. The bench provokes this by raising cfg_we in the exact cycle a point is taken, and again one cycle later while the point is in flight. The scoreboard computes the expected result from the coefficients that were in force at acceptance. A second overlap pairs a sink taking one output while the other output is held back. Random ready patterns provoke it, and the results are judged by matching every output against the queue, with no loss and no duplicate.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int AXES  = 3;
  localparam int TERMS = 4;
  localparam int NCOEF = AXES * TERMS;
  localparam int NSETS = 2;
  localparam int IDX_W = $clog2(NCOEF);

  typedef enum logic {
    XF_PARALLEL = 1'b0,
    XF_CHAINED  = 1'b1
  } xf_mode_e;
endpackage

// File: rtl/axf_coef_bank.sv
module axf_coef_bank
  import axf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  sel,
  input  logic [IDX_W-1:0]      idx,
  input  logic [CW-1:0]         data,
  output logic [NCOEF*CW-1:0]   set_l,
  output logic [NCOEF*CW-1:0]   set_r
);
  logic [CW-1:0] bank [NSETS][NCOEF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++)
        for (int i = 0; i < NCOEF; i++)
          bank[s][i] <= '0;
    end else if (we && (idx < IDX_W'(NCOEF))) begin
      bank[sel][idx] <= data;
    end
  end

  for (genvar i = 0; i < NCOEF; i++) begin : g_flat
    assign set_l[i*CW +: CW] = bank[0][i];
    assign set_r[i*CW +: CW] = bank[1][i];
  end
endmodule

// File: rtl/axf_affine.sv
module axf_affine
  import axf_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int AW = DW + CW + 2
) (
  input  logic [AXES*DW-1:0]  pt,
  input  logic [NCOEF*CW-1:0] cf,
  output logic [AXES*AW-1:0]  sum
);
  logic signed [AW-1:0] xe, ye, ze;
  assign xe = AW'($signed(pt[0*DW +: DW]));
  assign ye = AW'($signed(pt[1*DW +: DW]));
  assign ze = AW'($signed(pt[2*DW +: DW]));

  for (genvar r = 0; r < AXES; r++) begin : g_row
    logic signed [AW-1:0] k0, k1, k2, k3;
    assign k0 = AW'($signed(cf[(TERMS*r+0)*CW +: CW]));
    assign k1 = AW'($signed(cf[(TERMS*r+1)*CW +: CW]));
    assign k2 = AW'($signed(cf[(TERMS*r+2)*CW +: CW]));
    assign k3 = AW'($signed(cf[(TERMS*r+3)*CW +: CW]));
    assign sum[r*AW +: AW] = xe * k0 + ye * k1 + ze * k2 + k3;
  end
endmodule

// File: rtl/axf_sat.sv
module axf_sat #(
  parameter int IW = 28,
  parameter int OW = 16
) (
  input  logic [IW-1:0] din,
  output logic [OW-1:0] dout
);
  localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    if ($signed(din) > HI)      dout = HI[OW-1:0];
    else if ($signed(din) < LO) dout = LO[OW-1:0];
    else                        dout = din[OW-1:0];
  end
endmodule

// File: rtl/stereo_affine_xform.sv
module stereo_affine_xform
  import axf_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int IN_W    = 10,
  parameter int LANE_W  = 16,
  parameter int COORD_W = 16,
  parameter int CW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CW-1:0]      cfg_data,
  input  logic               chain_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               l_valid,
  input  logic               l_ready,
  output logic [COORD_W-1:0] l_x,
  output logic [COORD_W-1:0] l_y,
  output logic [COORD_W-1:0] l_z,
  output logic               r_valid,
  input  logic               r_ready,
  output logic [COORD_W-1:0] r_x,
  output logic [COORD_W-1:0] r_y,
  output logic [COORD_W-1:0] r_z
);
  localparam int ACC_L = IN_W + CW + 2;
  localparam int ACC_R = COORD_W + CW + 2;
  localparam int PT_W  = AXES * IN_W;
  localparam int CO_W  = AXES * COORD_W;
  localparam int CF_W  = NCOEF * CW;

  // coefficient storage
  logic [CF_W-1:0] coef_l, coef_r;
  axf_coef_bank #(.CW(CW)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
    .data(cfg_data), .set_l(coef_l), .set_r(coef_r)
  );

  // lane unpacking; the spare lane and gap bits are dropped
  logic [PT_W-1:0] in_pt;
  for (genvar g = 0; g < AXES; g++) begin : g_lane
    assign in_pt[g*IN_W +: IN_W] = in_word[g*LANE_W +: IN_W];
  end
  logic unused_word_bits;
  assign unused_word_bits = ^in_word;

  // flow control: the whole pipe moves or none of it does
  logic hold, adv;
  assign hold     = (l_valid & ~l_ready) | (r_valid & ~r_ready);
  assign adv      = ~hold;
  assign in_ready = adv;

  // set L is evaluated on the live registers at acceptance
  logic [AXES*ACC_L-1:0] sum_l;
  axf_affine #(.DW(IN_W), .CW(CW), .AW(ACC_L)) u_mac_l (
    .pt(in_pt), .cf(coef_l), .sum(sum_l)
  );

  // stage 1: exact set-L sums, raw point, frozen set R
  logic                  s1_v;
  xf_mode_e              s1_mode;
  logic [AXES*ACC_L-1:0] s1_sum;
  logic [PT_W-1:0]       s1_pt;
  logic [CF_W-1:0]       s1_cfr;

  always_ff @(posedge clk) begin
    if (rst)      s1_v <= 1'b0;
    else if (adv) s1_v <= in_valid;
  end
  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_mode <= xf_mode_e'(chain_en);
      s1_sum  <= sum_l;
      s1_pt   <= in_pt;
      s1_cfr  <= coef_r;
    end
  end

  logic [CO_W-1:0] s1_clamp;
  for (genvar g = 0; g < AXES; g++) begin : g_sat_l
    axf_sat #(.IW(ACC_L), .OW(COORD_W)) u_sat (
      .din(s1_sum[g*ACC_L +: ACC_L]), .dout(s1_clamp[g*COORD_W +: COORD_W])
    );
  end

  // stage 2: clamped set-L result
  logic            s2_v;
  xf_mode_e        s2_mode;
  logic [CO_W-1:0] s2_lres;
  logic [PT_W-1:0] s2_pt;
  logic [CF_W-1:0] s2_cfr;

  always_ff @(posedge clk) begin
    if (rst)      s2_v <= 1'b0;
    else if (adv) s2_v <= s1_v;
  end
  always_ff @(posedge clk) begin
    if (adv && s1_v) begin
      s2_mode <= s1_mode;
      s2_lres <= s1_clamp;
      s2_pt   <= s1_pt;
      s2_cfr  <= s1_cfr;
    end
  end

  // set R operand: raw point (parallel) or set-L result (chained)
  logic [CO_W-1:0] r_in;
  for (genvar g = 0; g < AXES; g++) begin : g_rsel
    assign r_in[g*COORD_W +: COORD_W] = (s2_mode == XF_CHAINED)
      ? s2_lres[g*COORD_W +: COORD_W]
      : COORD_W'($signed(s2_pt[g*IN_W +: IN_W]));
  end

  logic [AXES*ACC_R-1:0] sum_r;
  axf_affine #(.DW(COORD_W), .CW(CW), .AW(ACC_R)) u_mac_r (
    .pt(r_in), .cf(s2_cfr), .sum(sum_r)
  );

  logic [CO_W-1:0] r_clamp;
  for (genvar g = 0; g < AXES; g++) begin : g_sat_r
    axf_sat #(.IW(ACC_R), .OW(COORD_W)) u_sat (
      .din(sum_r[g*ACC_R +: ACC_R]), .dout(r_clamp[g*COORD_W +: COORD_W])
    );
  end

  // stage 3: output registers, each channel drained on its own
  logic [CO_W-1:0] l_q, r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_valid <= 1'b0;
      r_valid <= 1'b0;
    end else if (adv) begin
      l_valid <= s2_v;
      r_valid <= s2_v && (s2_mode == XF_PARALLEL);
    end else begin
      l_valid <= l_valid & ~l_ready;
      r_valid <= r_valid & ~r_ready;
    end
  end
  always_ff @(posedge clk) begin
    if (adv && s2_v) begin
      l_q <= (s2_mode == XF_CHAINED) ? r_clamp : s2_lres;
      r_q <= r_clamp;
    end
  end

  assign l_x = l_q[0*COORD_W +: COORD_W];
  assign l_y = l_q[1*COORD_W +: COORD_W];
  assign l_z = l_q[2*COORD_W +: COORD_W];
  assign r_x = r_q[0*COORD_W +: COORD_W];
  assign r_y = r_q[1*COORD_W +: COORD_W];
  assign r_z = r_q[2*COORD_W +: COORD_W];
endmodule

// File: rtl/stereo_affine_xform_chk.sv
module stereo_affine_xform_chk #(
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               l_valid,
  input logic               l_ready,
  input logic [COORD_W-1:0] l_x,
  input logic [COORD_W-1:0] l_y,
  input logic [COORD_W-1:0] l_z,
  input logic               r_valid,
  input logic               r_ready,
  input logic [COORD_W-1:0] r_x,
  input logic [COORD_W-1:0] r_y,
  input logic [COORD_W-1:0] r_z
);
  // R10: reset empties both outputs
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!l_valid && !r_valid));

  // R7: a refused left result stays put
  assert_hold_left_R7: assert property (@(posedge clk) disable iff (rst)
    (l_valid && !l_ready) |=> (l_valid && $stable(l_x) && $stable(l_y) && $stable(l_z)));

  // R7: a refused right result stays put
  assert_hold_right_R7: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_x) && $stable(r_y) && $stable(r_z)));

  // R7: no new input while either channel is blocked
  assert_no_accept_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    ((l_valid && !l_ready) || (r_valid && !r_ready)) |-> !in_ready);

  // R4: a new right result always comes with a left result
  assert_pair_together_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(r_valid) |-> l_valid);

  // R6: three unstalled cycles after acceptance the left result is present
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 3) && $past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> l_valid);
endmodule

bind stereo_affine_xform stereo_affine_xform_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .l_valid(l_valid), .l_ready(l_ready), .l_x(l_x), .l_y(l_y), .l_z(l_z),
  .r_valid(r_valid), .r_ready(r_ready), .r_x(r_x), .r_y(r_y), .r_z(r_z)
);

// File: tb/stereo_affine_xform_tb.sv
module stereo_affine_xform_tb;
  localparam int HP   = 2500;   // 200 MHz, time unit 1 ps
  localparam int LATE = 1500;   // sample point after the falling edge

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_sel, chain_en, in_valid, in_ready;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_data;
  logic [63:0] in_word;
  logic        l_valid, l_ready, r_valid, r_ready;
  logic [15:0] l_x, l_y, l_z, r_x, r_y, r_z;

  stereo_affine_xform u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .chain_en(chain_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .l_valid(l_valid), .l_ready(l_ready), .l_x(l_x), .l_y(l_y),
    .l_z(l_z), .r_valid(r_valid), .r_ready(r_ready), .r_x(r_x), .r_y(r_y), .r_z(r_z)
  );

  always #HP clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cm [2][12];
  logic [47:0] qa[$];
  logic [47:0] qb[$];
  string       ta[$];
  string       tr[$];
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] clamp16(input longint v);
    if (v > 32767)  return 16'h7fff;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [47:0] model(input int s, input longint px, input longint py,
                                        input longint pz);
    logic [47:0] res;
    for (int r = 0; r < 3; r++) begin
      longint acc;
      acc = px * cm[s][4*r] + py * cm[s][4*r+1] + pz * cm[s][4*r+2] + cm[s][4*r+3];
      res[r*16 +: 16] = clamp16(acc);
    end
    return res;
  endfunction

  function automatic logic [63:0] pack(input int x, input int y, input int z,
                                       input logic [63:0] junk);
    logic [63:0] w;
    w = junk;
    w[9:0]   = 10'(x);
    w[25:16] = 10'(y);
    w[41:32] = 10'(z);
    return w;
  endfunction

  // ready pattern for both sinks
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      1:       begin l_ready = lfsr[0] | lfsr[3]; r_ready = lfsr[5] | lfsr[8]; end
      2:       begin l_ready = 1'b1;              r_ready = lfsr[2] & lfsr[7]; end
      default: begin l_ready = 1'b1;              r_ready = 1'b1;              end
    endcase
  end

  // scoreboard monitor
  always begin
    @(negedge clk);
    #LATE;
    if (rst === 1'b0) begin
      if (l_valid && l_ready) begin
        if (qa.size() == 0) chk(0, "R4", "left result with nothing expected", {16'h0, l_z, l_y, l_x}, 64'h0);
        else begin
          logic [47:0] e;
          string t;
          e = qa.pop_front();
          t = ta.pop_front();
          chk({l_z, l_y, l_x} == e, t, "left result", {16'h0, l_z, l_y, l_x}, {16'h0, e});
        end
      end
      if (r_valid && r_ready) begin
        if (qb.size() == 0) chk(0, "R5", "right result with nothing expected", {16'h0, r_z, r_y, r_x}, 64'h0);
        else begin
          logic [47:0] e;
          string t;
          e = qb.pop_front();
          t = tr.pop_front();
          chk({r_z, r_y, r_x} == e, t, "right result", {16'h0, r_z, r_y, r_x}, {16'h0, e});
        end
      end
    end
  end

  // write one coefficient; called at a falling edge
  task automatic cfg_write(input int s, input int idx, input int v);
    cfg_we = 1'b1; cfg_sel = 1'(s); cfg_idx = 4'(idx); cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 12) cm[s][idx] = int'($signed(16'(v)));
  endtask

  task automatic load_set(input int s, input int v [12]);
    for (int i = 0; i < 12; i++) cfg_write(s, i, v[i]);
  endtask

  // drive one point; optional coefficient write in its acceptance cycle
  task automatic send(input logic [63:0] w, input bit chained, input string tag,
                      input bit wr, input int ws, input int wi, input int wv);
    in_word = w; chain_en = chained; in_valid = 1'b1;
    forever begin
      #LATE;
      if (in_ready) begin
        longint px, py, pz;
        logic [47:0] lres;
        px = longint'($signed(w[9:0]));
        py = longint'($signed(w[25:16]));
        pz = longint'($signed(w[41:32]));
        lres = model(0, px, py, pz);
        if (chained) begin
          qa.push_back(model(1, longint'($signed(lres[15:0])), longint'($signed(lres[31:16])),
                             longint'($signed(lres[47:32]))));
          ta.push_back(tag);
        end else begin
          qa.push_back(lres); ta.push_back(tag);
          qb.push_back(model(1, px, py, pz)); tr.push_back(tag);
        end
        if (wr) begin
          cfg_we = 1'b1; cfg_sel = 1'(ws); cfg_idx = 4'(wi); cfg_data = 16'(wv);
          if (wi < 12) cm[ws][wi] = int'($signed(16'(wv)));
        end
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (qa.size() == 0 && qb.size() == 0) break;
      @(negedge clk);
    end
    chk(qa.size() == 0 && qb.size() == 0, "R7", "all results delivered",
        64'(qa.size() + qb.size()), 64'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=hung expected=completion");
    summary();
  end

  initial begin
    int sa [12];
    int sb [12];
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_idx = '0; cfg_data = '0;
    chain_en = 1'b0; in_valid = 1'b0; in_word = '0;
    for (int s = 0; s < 2; s++) for (int i = 0; i < 12; i++) cm[s][i] = 0;
    repeat (3) @(negedge clk);
    #LATE;
    chk(!l_valid && !r_valid, "R10", "valid low in reset", {62'h0, l_valid, r_valid}, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #LATE;
    chk(in_ready === 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'h1);
    @(negedge clk);

    // R10: coefficients start at zero
    send(pack(100, -7, 33, 64'h0), 1'b0, "R10", 0, 0, 0, 0);
    drain();

    // R2: program both sets
    sa = '{1, 0, 0, 5, 0, 2, 0, -3, 0, 0, -1, 7};
    sb = '{0, 1, 0, 0, 1, 0, 0, 0, 1, 1, 1, 100};
    load_set(0, sa);
    load_set(1, sb);

    // R6: latency with free sinks
    send(pack(3, 4, 5, 64'h0), 1'b0, "R6", 0, 0, 0, 0);
    #LATE; chk(!l_valid, "R6", "not valid one cycle after", 64'(l_valid), 64'h0);
    @(negedge clk); #LATE; chk(!l_valid, "R6", "not valid two cycles after", 64'(l_valid), 64'h0);
    @(negedge clk); #LATE; chk(l_valid === 1'b1, "R6", "valid three cycles after", 64'(l_valid), 64'h1);
    @(negedge clk);
    drain();

    // R1: junk outside the lanes, extremes inside
    send(pack(511, -512, 0, 64'hFFFF_FC00_FC00_FC00), 1'b0, "R1", 0, 0, 0, 0);
    send(pack(-1, 1, -512, 64'hA5A5_5A5A_C3C3_3C3C), 1'b0, "R1", 0, 0, 0, 0);
    send(pack(17, -200, 301, 64'h03FF_0000_0000_0000), 1'b0, "R1", 0, 0, 0, 0);
    drain();

    // R2/R4: varied coefficients, parallel stream back to back
    sa = '{3, -2, 7, 11, -5, 4, 9, -100, 12, -13, 6, 250};
    sb = '{-9, 8, -1, 40, 2, 2, 2, 2, 0, 5, -7, -300};
    load_set(0, sa);
    load_set(1, sb);
    for (int i = 0; i < 20; i++)
      send(pack(i * 37 - 300, 200 - i * 23, i * i - 150, 64'h0), 1'b0, "R4", 0, 0, 0, 0);
    drain();

    // R3: clamping high and low, exact edge values
    sa = '{32767, 0, 0, 0, 0, -32768, 0, 0, 0, 0, 0, 32767};
    sb = '{1, 0, 0, 32766, 0, 1, 0, -32767, 0, 0, 64, 0};
    load_set(0, sa);
    load_set(1, sb);
    send(pack(511, 511, 0, 64'h0), 1'b0, "R3", 0, 0, 0, 0);
    send(pack(1, -1, 511, 64'h0), 1'b0, "R3", 0, 0, 0, 0);
    send(pack(-512, 1, -512, 64'h0), 1'b0, "R3", 0, 0, 0, 0);
    send(pack(2, -2, 1, 64'h0), 1'b0, "R3", 0, 0, 0, 0);

    // R5: chained points, including clamp between stages
    sa = '{2, 1, 0, -10, 0, 3, -1, 20, 1, 1, 1, 0};
    sb = '{1, -1, 0, 0, 100, 0, 0, 5, 0, 0, -200, 1};
    load_set(0, sa);
    load_set(1, sb);
    for (int i = 0; i < 8; i++)
      send(pack(i * 60 - 240, 15 - i * 9, 400 - i * 100, 64'h0), 1'b1, "R5", 0, 0, 0, 0);
    drain();

    // R8: write in the acceptance cycle and right after it
    send(pack(50, 60, 70, 64'h0), 1'b0, "R8", 1, 0, 0, 999);
    send(pack(-50, 6, 7, 64'h0), 1'b0, "R8", 1, 1, 3, -4321);
    cfg_write(1, 4, 777);
    send(pack(8, 9, 10, 64'h0), 1'b1, "R8", 1, 1, 8, 31);
    cfg_write(0, 11, -1);
    send(pack(120, -121, 122, 64'h0), 1'b0, "R8", 0, 0, 0, 0);
    drain();

    // R9: out-of-range indices leave every coefficient alone
    cfg_write(0, 12, 16'h7fff);
    cfg_write(0, 13, 16'h1234);
    cfg_write(1, 14, 16'h8000);
    cfg_write(1, 15, 16'h5555);
    send(pack(11, 22, 33, 64'h0), 1'b0, "R9", 0, 0, 0, 0);
    send(pack(-11, 0, 99, 64'h0), 1'b1, "R9", 1, 0, 12, 500);
    send(pack(7, -7, 7, 64'h0), 1'b0, "R9", 0, 0, 0, 0);
    drain();

    // R7/R11: random backpressure, mixed modes
    rdy_mode = 1;
    for (int i = 0; i < 60; i++)
      send(pack(i * 17 - 500, 300 - i * 11, (i * 29) % 500 - 250, 64'hDEAD_0000_BEEF_0000),
           bit'((i % 3) == 1), (i % 2) ? "R11" : "R7", 0, 0, 0, 0);
    rdy_mode = 2;
    for (int i = 0; i < 40; i++)
      send(pack(i * 5 - 100, i * 3, -i * 7, 64'h0), bit'(i[2]), "R7", 0, 0, 0, 0);
    drain();
    rdy_mode = 0;
    @(negedge clk);
    summary();
  end
endmodule